// File: doc/BRIEF.md
# Go-Back-N Link Retransmission Controller

This block gives a serial link reliable delivery. It assumes that bit errors will occur now and then, and it recovers from them without treating them as fatal. The transmit half gives each outgoing packet an 8-bit sequence number that wraps. It keeps a copy of each packet in a replay store until the partner acknowledges it. The transmitter stops taking packets once 32 are outstanding.

The receive half checks each arriving packet against the sequence number it expects and against the error flags from the deframer and the physical layer. A good packet is delivered and acknowledged. The first bad packet or error event produces one negative acknowledgement that names the sequence number expected. After that, everything is dropped until that number arrives again without error.

A negative acknowledgement from the partner rewinds the transmitter to the named packet. The transmitter then resends that packet and every later one before it takes new traffic. Errors the partner finds on its side therefore cause the same recovery. A programmable timer also rewinds to the oldest unacknowledged packet if the partner stays silent, which covers a lost acknowledgement.

Top module: `replay_link_ctrl`

## Requirements
- R1: When no replay is pending, an accepted transmit packet appears on tx_out in the same cycle with its payload unchanged. Sequence numbers count up from 0 after reset and wrap modulo 256.
- R2: tx_in_ready is low while 32 packets are unacknowledged.
- R3: An acknowledgement (rx_ctl_nack=0) carrying N, where N lies within the outstanding window, frees N and every older entry. An acknowledgement outside the window changes nothing.
- R4: A negative acknowledgement (rx_ctl_nack=1) carrying N within the window makes the transmitter resend N and every later packet. They go out in their original order with their original sequence numbers and payloads.
- R5: While replayed packets remain to be sent, tx_in_ready is low. New packets follow only after the last replayed packet.
- R6: With packets outstanding, if cfg_timeout cycles pass with no accepted acknowledgement or negative acknowledgement, the transmitter resends starting from the oldest unacknowledged packet.
- R7: A packet with the expected sequence number and no error flag is presented on rx_out one cycle later. In that same cycle an acknowledgement carrying its sequence number is issued (tx_ctl_nack=0).
- R8: A packet with rx_in_err high, or with an unexpected sequence number, is not delivered. One cycle later a negative acknowledgement (tx_ctl_nack=1) carries the expected sequence number.
- R9: A phy_err pulse, with or without a packet in the same cycle, starts recovery exactly as R8 does.
- R10: After an error, every packet is dropped until the expected sequence number arrives error-free, and no second negative acknowledgement is sent within that episode. Normal delivery then resumes.
- R11: After reset, every valid output is low, tx_in_ready is high when tx_out_ready is high, and the receiver expects sequence number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout | input | 16 | Replay timer limit in cycles, must be at least 1 |
| tx_in_valid | input | 1 | New packet offered for transmission |
| tx_in_ready | output | 1 | New packet accepted this cycle |
| tx_in_data | input | 32 | New packet payload |
| tx_out_valid | output | 1 | Packet presented to the framer |
| tx_out_ready | input | 1 | Framer takes the packet |
| tx_out_data | output | 32 | Outgoing payload |
| tx_out_seq | output | 8 | Outgoing sequence number |
| rx_ctl_valid | input | 1 | Control flit received from partner |
| rx_ctl_nack | input | 1 | 1 = negative acknowledgement, 0 = acknowledgement |
| rx_ctl_seq | input | 8 | Sequence number in received control flit |
| rx_in_valid | input | 1 | Packet from deframer |
| rx_in_data | input | 32 | Incoming payload |
| rx_in_seq | input | 8 | Incoming sequence number |
| rx_in_err | input | 1 | CRC, framing or consistency error on this packet |
| phy_err | input | 1 | Line coding error this cycle |
| rx_out_valid | output | 1 | Delivered packet |
| rx_out_data | output | 32 | Delivered payload |
| rx_out_seq | output | 8 | Delivered sequence number |
| tx_ctl_valid | output | 1 | Control flit to send to partner |
| tx_ctl_nack | output | 1 | 1 = negative acknowledgement, 0 = acknowledgement |
| tx_ctl_seq | output | 8 | Sequence number in outgoing control flit |

## Verification
The transmit path is tried with a plain burst, with a partial acknowledgement followed by a rewind, and with a stale acknowledgement against a full store. It is also run with a long acknowledged stream that crosses the sequence wrap, and with a single packet left unacknowledged until the timer fires. These show apart in-order forwarding, window bookkeeping, rewind order and the timer path. The receive path gets an in-order run, a flagged packet, a sequence gap and bare line errors, each followed by packets sent while discarding. This shows whether the controller delivers, drops, or issues exactly one recovery request.

// File: rtl/rlc_pkg.sv
// Shared types of the link retransmission controller.
package rlc_pkg;
    // Kind of a control flit on either control channel.
    typedef enum logic {
        CTL_ACK  = 1'b0,
        CTL_NACK = 1'b1
    } ctl_kind_e;
endpackage

// File: rtl/rlc_replay_store.sv
// Replay storage: one slot per outstanding packet, indexed by the low bits
// of the sequence number. One write port, one asynchronous read port.
// Assumes the sequencer never overwrites a slot that is still outstanding.
module rlc_replay_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slots [DEPTH];

    // Capture each newly sent packet in its slot.
    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_data;
    end

    assign rd_data = slots[rd_idx];
endmodule

// File: rtl/rlc_tx_seq.sv
// Transmit sequencer. It holds three sequence pointers: the oldest
// unacknowledged packet, the next number to read out, and the next number
// to assign. It handles acknowledgements, negative acknowledgements and the
// replay timer. When the read and assign pointers differ, a replay is pending
// and the store drives the output. Otherwise new input passes straight through.
// Assumes DEPTH < 2**SEQ_W and cfg_timeout >= 1.
module rlc_tx_seq
    import rlc_pkg::*;
#(
    parameter int SEQ_W   = 8,
    parameter int DEPTH   = 32,
    parameter int TIMER_W = 16,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] cfg_timeout,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               out_ready,
    output logic               out_valid,
    output logic               out_from_store,
    output logic [SEQ_W-1:0]   out_seq,
    input  logic               ctl_valid,
    input  ctl_kind_e          ctl_kind,
    input  logic [SEQ_W-1:0]   ctl_seq,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [IDX_W-1:0]   rd_idx
);
    localparam logic [SEQ_W-1:0] DEPTH_S = SEQ_W'(DEPTH);
    localparam logic [SEQ_W-1:0] ONE_S   = SEQ_W'(1);

    logic [SEQ_W-1:0]   base_seq, rd_seq, next_seq;
    logic [TIMER_W-1:0] timer;
    logic [SEQ_W-1:0]   pending, ctl_off, rd_adv;
    logic               replaying, full, accept, replay_fire;
    logic               in_window, ack_ok, nack_ok, expired;

    // Window size, pending state and decode of control flits.
    always_comb begin
        pending     = next_seq - base_seq;
        replaying   = (rd_seq != next_seq);
        full        = (pending == DEPTH_S);
        in_ready    = out_ready && !full && !replaying;
        accept      = in_valid && in_ready;
        out_valid   = replaying || (in_valid && !full);
        replay_fire = replaying && out_ready;
        ctl_off     = ctl_seq - base_seq;
        in_window   = (ctl_off < pending);
        ack_ok      = ctl_valid && (ctl_kind == CTL_ACK)  && in_window;
        nack_ok     = ctl_valid && (ctl_kind == CTL_NACK) && in_window;
        expired     = (pending != '0) && (timer == cfg_timeout);
        rd_adv      = rd_seq + ((accept || replay_fire) ? ONE_S : '0);
    end

    assign out_from_store = replaying;
    assign out_seq        = rd_seq;
    assign wr_en          = accept;
    assign wr_idx         = next_seq[IDX_W-1:0];
    assign rd_idx         = rd_seq[IDX_W-1:0];

    // Advance the assign pointer on every accepted new packet.
    always_ff @(posedge clk) begin
        if (!rst_n)      next_seq <= '0;
        else if (accept) next_seq <= next_seq + ONE_S;
    end

    // Move the oldest-outstanding pointer on acknowledgements and rewinds.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_seq <= '0;
        else if (nack_ok) base_seq <= ctl_seq;
        else if (ack_ok)  base_seq <= ctl_seq + ONE_S;
    end

    // Read pointer: a rewind has priority, then the timer, then the normal advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_seq <= '0;
        else if (nack_ok)
            rd_seq <= ctl_seq;
        else if (expired)
            rd_seq <= base_seq;
        else if (ack_ok && ((ctl_off + ONE_S) > (rd_adv - base_seq)))
            rd_seq <= ctl_seq + ONE_S;
        else
            rd_seq <= rd_adv;
    end

    // Replay timer: counts idle cycles while packets are outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timer <= '0;
        else if ((pending == '0) || ack_ok || nack_ok || expired)
            timer <= '0;
        else
            timer <= timer + TIMER_W'(1);
    end
endmodule

// File: rtl/rlc_rx_check.sv
// Receive checker. It compares each packet with the expected sequence number
// and with the error flags. It delivers and acknowledges good packets. On the
// first error of an episode it issues one negative acknowledgement, then drops
// everything until the expected number arrives clean again.
// Assumes at most one packet per cycle.
module rlc_rx_check
    import rlc_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic              in_err,
    input  logic              phy_err,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [SEQ_W-1:0]  out_seq,
    output logic              ctl_valid,
    output ctl_kind_e         ctl_kind,
    output logic [SEQ_W-1:0]  ctl_seq
);
    logic [SEQ_W-1:0] exp_seq;
    logic             discarding;
    logic             good, bad, raise_nack;

    // Classify the current cycle.
    always_comb begin
        good       = in_valid && !in_err && !phy_err && (in_seq == exp_seq);
        bad        = phy_err || (in_valid && (in_err || (in_seq != exp_seq)));
        raise_nack = bad && !discarding;
    end

    // Expected number and discard state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_seq    <= '0;
            discarding <= 1'b0;
        end else if (good) begin
            exp_seq    <= exp_seq + SEQ_W'(1);
            discarding <= 1'b0;
        end else if (bad) begin
            discarding <= 1'b1;
        end
    end

    // Registered delivery of good packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_seq   <= '0;
        end else begin
            out_valid <= good;
            if (good) begin
                out_data <= in_data;
                out_seq  <= in_seq;
            end
        end
    end

    // Registered control flit: an ack for a good packet, a nack once per episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_valid <= 1'b0;
            ctl_kind  <= CTL_ACK;
            ctl_seq   <= '0;
        end else begin
            ctl_valid <= good || raise_nack;
            ctl_kind  <= good ? CTL_ACK : CTL_NACK;
            ctl_seq   <= good ? in_seq : exp_seq;
        end
    end
endmodule

// File: rtl/replay_link_ctrl.sv
// Top of the go-back-N link retransmission controller. It joins the transmit
// sequencer, its replay store and the receive checker. Control flits are
// assumed to be taken by the link every cycle, without backpressure.
module replay_link_ctrl
    import rlc_pkg::*;
#(
    parameter int SEQ_W   = 8,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 32,
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] cfg_timeout,
    input  logic               tx_in_valid,
    output logic               tx_in_ready,
    input  logic [DATA_W-1:0]  tx_in_data,
    output logic               tx_out_valid,
    input  logic               tx_out_ready,
    output logic [DATA_W-1:0]  tx_out_data,
    output logic [SEQ_W-1:0]   tx_out_seq,
    input  logic               rx_ctl_valid,
    input  logic               rx_ctl_nack,
    input  logic [SEQ_W-1:0]   rx_ctl_seq,
    input  logic               rx_in_valid,
    input  logic [DATA_W-1:0]  rx_in_data,
    input  logic [SEQ_W-1:0]   rx_in_seq,
    input  logic               rx_in_err,
    input  logic               phy_err,
    output logic               rx_out_valid,
    output logic [DATA_W-1:0]  rx_out_data,
    output logic [SEQ_W-1:0]   rx_out_seq,
    output logic               tx_ctl_valid,
    output logic               tx_ctl_nack,
    output logic [SEQ_W-1:0]   tx_ctl_seq
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              wr_en, from_store;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] store_data;
    ctl_kind_e         rx_kind, tx_kind;

    assign rx_kind = rx_ctl_nack ? CTL_NACK : CTL_ACK;

    rlc_tx_seq #(
        .SEQ_W(SEQ_W), .DEPTH(DEPTH), .TIMER_W(TIMER_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .in_valid(tx_in_valid), .in_ready(tx_in_ready),
        .out_ready(tx_out_ready), .out_valid(tx_out_valid),
        .out_from_store(from_store), .out_seq(tx_out_seq),
        .ctl_valid(rx_ctl_valid), .ctl_kind(rx_kind), .ctl_seq(rx_ctl_seq),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx)
    );

    rlc_replay_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(tx_in_data),
        .rd_idx(rd_idx), .rd_data(store_data)
    );

    // A replay reads from the store. Otherwise the new packet passes straight through.
    assign tx_out_data = from_store ? store_data : tx_in_data;

    rlc_rx_check #(
        .SEQ_W(SEQ_W), .DATA_W(DATA_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_in_valid), .in_data(rx_in_data), .in_seq(rx_in_seq),
        .in_err(rx_in_err), .phy_err(phy_err),
        .out_valid(rx_out_valid), .out_data(rx_out_data), .out_seq(rx_out_seq),
        .ctl_valid(tx_ctl_valid), .ctl_kind(tx_kind), .ctl_seq(tx_ctl_seq)
    );

    assign tx_ctl_nack = (tx_kind == CTL_NACK);
endmodule

// File: rtl/rlc_chk.sv
// Property checker for replay_link_ctrl, attached to it with bind.
module rlc_chk #(
    parameter int SEQ_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_in_valid,
    input logic              tx_in_ready,
    input logic [DATA_W-1:0] tx_in_data,
    input logic              tx_out_valid,
    input logic [DATA_W-1:0] tx_out_data,
    input logic              rx_in_valid,
    input logic              rx_in_err,
    input logic              phy_err,
    input logic              rx_out_valid,
    input logic [SEQ_W-1:0]  rx_out_seq,
    input logic              tx_ctl_valid,
    input logic              tx_ctl_nack,
    input logic [SEQ_W-1:0]  tx_ctl_seq
);
    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_ready) |-> (tx_out_valid && tx_out_data == tx_in_data));

    // R5
    replay_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_in_valid) |-> !tx_in_ready);

    // R7
    deliver_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> (tx_ctl_valid && !tx_ctl_nack && tx_ctl_seq == rx_out_seq));

    // R8
    flagged_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && rx_in_err) |=> !rx_out_valid);

    // R9
    phy_err_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_err |=> !rx_out_valid);

    // R10
    single_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctl_valid && tx_ctl_nack) |=> !(tx_ctl_valid && tx_ctl_nack));
endmodule

bind replay_link_ctrl rlc_chk #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_err(rx_in_err), .phy_err(phy_err),
    .rx_out_valid(rx_out_valid), .rx_out_seq(rx_out_seq),
    .tx_ctl_valid(tx_ctl_valid), .tx_ctl_nack(tx_ctl_nack), .tx_ctl_seq(tx_ctl_seq)
);

// File: tb/replay_link_ctrl_tb.sv
// Scoreboard bench: driver tasks queue what each output must show,
// monitors at the falling edge pop and compare.
module replay_link_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_timeout = 16'hFFFF;
    logic        tx_in_valid = 1'b0, tx_in_ready;
    logic [31:0] tx_in_data = '0;
    logic        tx_out_valid, tx_out_ready = 1'b1;
    logic [31:0] tx_out_data;
    logic [7:0]  tx_out_seq;
    logic        rx_ctl_valid = 1'b0, rx_ctl_nack = 1'b0;
    logic [7:0]  rx_ctl_seq = '0;
    logic        rx_in_valid = 1'b0, rx_in_err = 1'b0, phy_err = 1'b0;
    logic [31:0] rx_in_data = '0;
    logic [7:0]  rx_in_seq = '0;
    logic        rx_out_valid;
    logic [31:0] rx_out_data;
    logic [7:0]  rx_out_seq;
    logic        tx_ctl_valid, tx_ctl_nack;
    logic [7:0]  tx_ctl_seq;

    int checks = 0, errors = 0;
    int cycle = 0, tx_fires = 0, last_fire_cycle = 0;
    bit done = 1'b0;
    logic [39:0] tx_q[$];
    logic [39:0] rx_q[$];
    logic [8:0]  ctl_q[$];
    logic [31:0] hist [256];
    int b_next = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    replay_link_ctrl u_dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Transmit monitor: compare every packet taken by the framer.
    always @(negedge clk) begin
        if (rst_n && tx_out_valid && tx_out_ready) begin
            if (tx_q.size() == 0) check("R1/R4 unexpected tx packet", {tx_out_seq, tx_out_data}, 40'h0);
            else check("R1/R4 tx seq+data", {tx_out_seq, tx_out_data}, tx_q.pop_front());
            tx_fires++;
            last_fire_cycle = cycle;
        end
        if (rst_n && rx_out_valid) begin
            if (rx_q.size() == 0) check("R7/R10 unexpected delivery", {rx_out_seq, rx_out_data}, 40'h0);
            else check("R7 rx delivery", {rx_out_seq, rx_out_data}, rx_q.pop_front());
        end
        if (rst_n && tx_ctl_valid) begin
            if (ctl_q.size() == 0) check("R10 unexpected control flit", {tx_ctl_nack, tx_ctl_seq}, 9'h0);
            else check("R7/R8 control flit", {tx_ctl_nack, tx_ctl_seq}, ctl_q.pop_front());
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic tx_send(input logic [31:0] d);
        tx_q.push_back({8'(b_next), d});
        hist[b_next % 256] = d;
        b_next++;
        tx_in_valid = 1'b1;
        tx_in_data  = d;
        forever begin
            @(negedge clk);
            if (tx_in_ready) break;
        end
        @(posedge clk); #1;
        tx_in_valid = 1'b0;
    endtask

    task automatic ctl_in(input logic nack, input int s);
        if (nack)
            for (int k = s; k < b_next; k++) tx_q.push_back({8'(k), hist[k % 256]});
        rx_ctl_valid = 1'b1;
        rx_ctl_nack  = nack;
        rx_ctl_seq   = 8'(s);
        @(posedge clk); #1;
        rx_ctl_valid = 1'b0;
    endtask

    // kind: 0 = nothing expected, 1 = delivery + ack, 2 = nack naming nseq
    task automatic rx_send(input int s, input logic [31:0] d, input logic err,
                           input int kind, input int nseq);
        if (kind == 1) begin
            rx_q.push_back({8'(s), d});
            ctl_q.push_back({1'b0, 8'(s)});
        end else if (kind == 2) begin
            ctl_q.push_back({1'b1, 8'(nseq)});
        end
        rx_in_valid = 1'b1; rx_in_seq = 8'(s); rx_in_data = d; rx_in_err = err;
        @(posedge clk); #1;
        rx_in_valid = 1'b0; rx_in_err = 1'b0;
        idle(1);
    endtask

    task automatic phy_pulse(input bit expect_nack, input int nseq);
        if (expect_nack) ctl_q.push_back({1'b1, 8'(nseq)});
        phy_err = 1'b1;
        @(posedge clk); #1;
        phy_err = 1'b0;
        idle(1);
    endtask

    task automatic finish_run();
        check("R1 tx queue drained", 64'(tx_q.size()), 64'd0);
        check("R7 rx queue drained", 64'(rx_q.size()), 64'd0);
        check("R8 ctl queue drained", 64'(ctl_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 tx_out_valid", 64'(tx_out_valid), 64'd0);
        check("R11 rx_out_valid", 64'(rx_out_valid), 64'd0);
        check("R11 tx_ctl_valid", 64'(tx_ctl_valid), 64'd0);
        check("R11 tx_in_ready", 64'(tx_in_ready), 64'd1);
        @(posedge clk); #1;

        // R1: burst of five
        for (int i = 0; i < 5; i++) tx_send(32'hA000_0000 + i);
        // R3 partial ack, then R4 rewind to 3
        ctl_in(1'b0, 2);
        ctl_in(1'b1, 3);
        @(negedge clk);
        check("R5 ready low during replay", 64'(tx_in_ready), 64'd0);
        @(posedge clk); #1;
        tx_send(32'hA000_0005); // must follow the replay
        idle(3);
        ctl_in(1'b0, 5);

        // R2: fill the store
        for (int i = 0; i < 32; i++) tx_send(32'hB000_0000 + i);
        @(negedge clk);
        check("R2 ready low when full", 64'(tx_in_ready), 64'd0);
        @(posedge clk); #1;
        ctl_in(1'b0, 2); // outside the window
        @(negedge clk);
        check("R3 stale ack ignored", 64'(tx_in_ready), 64'd0);
        @(posedge clk); #1;
        ctl_in(1'b0, 6);
        @(negedge clk);
        check("R3 ack frees entry", 64'(tx_in_ready), 64'd1);
        @(posedge clk); #1;
        ctl_in(1'b0, b_next - 1);

        // R1: wrap of the sequence number
        for (int i = 0; i < 250; i++) begin
            tx_send(32'hC000_0000 + i);
            ctl_in(1'b0, b_next - 1);
        end

        // R6: replay timer
        cfg_timeout = 16'd20;
        idle(2);
        tx_q.push_back({8'(b_next), 32'hD00D_0001});
        tx_send(32'hD00D_0001);
        t0 = last_fire_cycle;
        while (tx_fires < 0 || tx_q.size() != 0) idle(1);
        check("R6 timer replay window", 64'((last_fire_cycle - t0) >= 20 && (last_fire_cycle - t0) <= 24), 64'd1);
        ctl_in(1'b0, b_next - 1);
        idle(4);

        // R7: in-order receive
        rx_send(0, 32'h1111_0000, 1'b0, 1, 0);
        rx_send(1, 32'h1111_0001, 1'b0, 1, 0);
        rx_send(2, 32'h1111_0002, 1'b0, 1, 0);
        // R8: flagged packet, then R10 discard and resume
        rx_send(3, 32'h1111_0003, 1'b1, 2, 3);
        rx_send(4, 32'h1111_0004, 1'b0, 0, 0);
        rx_send(3, 32'h1111_0003, 1'b0, 1, 0);
        // R8: sequence gap
        rx_send(5, 32'h1111_0005, 1'b0, 2, 4);
        rx_send(4, 32'h1111_0004, 1'b0, 1, 0);
        // R9: bare line error, second one in the episode silent (R10)
        phy_pulse(1'b1, 5);
        phy_pulse(1'b0, 0);
        rx_send(6, 32'h1111_0006, 1'b0, 0, 0);
        rx_send(5, 32'h1111_0005, 1'b0, 1, 0);
        idle(4);
        done = 1'b1;
        finish_run();
    end
endmodule